// File: doc/BRIEF.md
# Accumulator Register-Operation Execute Unit

This block holds a 16-bit accumulator and a one-bit extension flag, and carries out the register-only instruction group of a small accumulator machine. The group is recognised elsewhere, when the decoded opcode is 7, the indirect bit is clear and the sequencer is in step T3. In that step the surrounding control raises `exec_en` and presents the low twelve instruction bits on `op_sel`. Each of those bits enables one micro-operation of its own. Instruction words of this group therefore have the form 7xxx, for example 7800 to clear the accumulator or 7001 to halt.

On the clock edge that ends the execute step, the block updates the accumulator and the flag. During that step it also drives three combinational requests, each computed from the values the registers held before the edge:
- a skip request, which tells the sequencer to advance the program counter once more;
- a halt request, which clears the machine's run flip-flop;
- a step-counter clear, so that the next cycle starts again at T0.

Other instructions, such as loads and adds, write the accumulator through a plain load path that the rest of the datapath drives.

Top module: `acc_regop_unit`

## Requirements
- R1: While `rst_n` is low, `acc_q` is 0 and `ext_q` is 0.
- R2: While `exec_en` is low, `skip_req`, `halt_req` and `sc_clr` are 0. If `ld_en` is also low, `acc_q` and `ext_q` hold their values. If `ld_en` is high, `acc_q` takes `ld_acc` and `ext_q` takes `ld_ext` at the next edge.
- R3: Whenever `exec_en` is high, `sc_clr` is 1, whatever `op_sel` holds (including zero).
- R4: `op_sel[11]` sets the accumulator to 0. `op_sel[10]` sets the flag to 0.
- R5: `op_sel[9]` inverts every accumulator bit. `op_sel[8]` inverts the flag.
- R6: `op_sel[7]` rotates right through the flag. The accumulator shifts right by one, its bit 15 takes the old flag, and the flag takes the old bit 0.
- R7: `op_sel[6]` rotates left through the flag. The accumulator shifts left by one, its bit 0 takes the old flag, and the flag takes the old bit 15.
- R8: `op_sel[5]` adds one to the accumulator modulo 2^16 (FFFF becomes 0000) and leaves the flag unchanged.
- R9: `op_sel[4]` requests a skip when accumulator bit 15 is 0. `op_sel[3]` requests a skip when bit 15 is 1.
- R10: `op_sel[2]` requests a skip when the accumulator is 0. `op_sel[1]` requests a skip when the flag is 0.
- R11: `halt_req` is 1 exactly when `exec_en` and `op_sel[0]` are both 1.
- R12: When several select bits are set, each operation reads the old register values. The accumulator takes the result of the highest-numbered accumulator-writing bit set, in the order 11, 9, 7, 6, 5. The flag takes the result of the highest-numbered flag-writing bit set, in the order 10, 8, 7, 6. `skip_req` is the OR of all the enabled skip conditions, each tested on the old values.
- R13: When `exec_en` and `ld_en` are both high, the execute result is written and the load values are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_en | input | 1 | Register-operation execute step (opcode 7, direct, T3) |
| op_sel | input | 12 | Low instruction bits, one micro-operation per bit |
| ld_en | input | 1 | Load strobe from the rest of the datapath |
| ld_acc | input | 16 | Accumulator load value |
| ld_ext | input | 1 | Flag load value |
| acc_q | output | 16 | Accumulator |
| ext_q | output | 1 | Extension flag |
| skip_req | output | 1 | Advance the program counter one extra word |
| halt_req | output | 1 | Clear the run flip-flop |
| sc_clr | output | 1 | Clear the step counter |

## Verification
A wrong accumulator or flag value becomes visible on `acc_q` and `ext_q` one edge after the faulty step. It also shows in the same cycle as a wrong `skip_req` on any later sign, zero or flag test. A fault in the rotate or priority logic corrupts the 17-bit pair, and this persists until a clear or load overwrites it. The random mix of multi-bit selects and loads therefore exposes it within a few steps. Errors in the skip and halt decode are purely combinational and appear in the very step that uses the faulty bit.

// File: rtl/regop_pkg.sv
package regop_pkg;
  parameter int ACC_W = 16;
  parameter int SEL_W = 12;

  // select bit positions (behavioural: each bit is its own micro-op)
  localparam int B_CLR_ACC = 11;
  localparam int B_CLR_EXT = 10;
  localparam int B_INV_ACC = 9;
  localparam int B_INV_EXT = 8;
  localparam int B_ROT_R   = 7;
  localparam int B_ROT_L   = 6;
  localparam int B_INC     = 5;
  localparam int B_SK_POS  = 4;
  localparam int B_SK_NEG  = 3;
  localparam int B_SK_ZAC  = 2;
  localparam int B_SK_ZEX  = 1;
  localparam int B_HALT    = 0;

  typedef struct packed {
    logic pos;
    logic neg;
    logic zac;
    logic zex;
  } skip_hits_t;
endpackage

// File: rtl/regop_acc_next.sv
module regop_acc_next
  import regop_pkg::*;
#(
  parameter int W = ACC_W
) (
  input  logic [W-1:0]     acc,
  input  logic             ext,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     acc_n,
  output logic             ext_n
);
  function automatic logic [W-1:0] rot_r_acc(input logic [W-1:0] a, input logic e);
    logic [W-1:0] r;
    r        = a >> 1;
    r[W-1]   = e;
    return r;
  endfunction

  function automatic logic [W-1:0] rot_l_acc(input logic [W-1:0] a, input logic e);
    logic [W-1:0] r;
    r    = a << 1;
    r[0] = e;
    return r;
  endfunction

  function automatic logic [W-1:0] inc_acc(input logic [W-1:0] a);
    return a + W'(1);
  endfunction

  always_comb begin
    if (sel[B_CLR_ACC])      acc_n = '0;
    else if (sel[B_INV_ACC]) acc_n = ~acc;
    else if (sel[B_ROT_R])   acc_n = rot_r_acc(acc, ext);
    else if (sel[B_ROT_L])   acc_n = rot_l_acc(acc, ext);
    else if (sel[B_INC])     acc_n = inc_acc(acc);
    else                     acc_n = acc;
  end

  always_comb begin
    if (sel[B_CLR_EXT])      ext_n = 1'b0;
    else if (sel[B_INV_EXT]) ext_n = ~ext;
    else if (sel[B_ROT_R])   ext_n = acc[0];
    else if (sel[B_ROT_L])   ext_n = acc[W-1];
    else                     ext_n = ext;
  end
endmodule

// File: rtl/regop_skip_eval.sv
module regop_skip_eval
  import regop_pkg::*;
#(
  parameter int W = ACC_W
) (
  input  logic             en,
  input  logic [W-1:0]     acc,
  input  logic             ext,
  input  logic [SEL_W-1:0] sel,
  output skip_hits_t       hits,
  output logic             skip,
  output logic             halt
);
  always_comb begin
    hits.pos = sel[B_SK_POS] & ~acc[W-1];
    hits.neg = sel[B_SK_NEG] &  acc[W-1];
    hits.zac = sel[B_SK_ZAC] & (acc == '0);
    hits.zex = sel[B_SK_ZEX] & ~ext;
  end

  assign skip = en & (|hits);
  assign halt = en & sel[B_HALT];
endmodule

// File: rtl/acc_regop_unit.sv
module acc_regop_unit
  import regop_pkg::*;
#(
  parameter int W = ACC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_en,
  input  logic [SEL_W-1:0] op_sel,
  input  logic             ld_en,
  input  logic [W-1:0]     ld_acc,
  input  logic             ld_ext,
  output logic [W-1:0]     acc_q,
  output logic             ext_q,
  output logic             skip_req,
  output logic             halt_req,
  output logic             sc_clr
);
  localparam logic [SEL_W-1:0] ONLY_ROT_R = SEL_W'(1) << B_ROT_R;
  localparam logic [SEL_W-1:0] ONLY_INC   = SEL_W'(1) << B_INC;
  localparam logic [SEL_W-1:0] ONLY_SZA   = SEL_W'(1) << B_SK_ZAC;

  logic [W-1:0] acc_exec;
  logic         ext_exec;
  skip_hits_t   hit_w;

  regop_acc_next #(.W(W)) u_next (
    .acc(acc_q), .ext(ext_q), .sel(op_sel),
    .acc_n(acc_exec), .ext_n(ext_exec)
  );

  regop_skip_eval #(.W(W)) u_skip (
    .en(exec_en), .acc(acc_q), .ext(ext_q), .sel(op_sel),
    .hits(hit_w), .skip(skip_req), .halt(halt_req)
  );

  assign sc_clr = exec_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      ext_q <= 1'b0;
    end else if (exec_en) begin
      acc_q <= acc_exec;
      ext_q <= ext_exec;
    end else if (ld_en) begin
      acc_q <= ld_acc;
      ext_q <= ld_ext;
    end
  end

  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |-> !skip_req && !halt_req && !sc_clr);

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en && !ld_en |=> $stable(acc_q) && $stable(ext_q));

  p_clear_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op_sel[B_CLR_ACC] |=> acc_q == '0);

  p_rot_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op_sel == ONLY_ROT_R |=>
      acc_q == {$past(ext_q), $past(acc_q[W-1:1])} && ext_q == $past(acc_q[0]));

  p_inc_keeps_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op_sel == ONLY_INC |=> ext_q == $past(ext_q));

  p_skip_on_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op_sel == ONLY_SZA && acc_q == '0 |-> skip_req);

  p_exec_beats_load_r13: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && ld_en && op_sel[B_CLR_ACC] |=> acc_q == '0);
endmodule

// File: tb/acc_regop_unit_tb.sv
module acc_regop_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_en = 1'b0;
  logic [11:0] op_sel = '0;
  logic        ld_en = 1'b0;
  logic [15:0] ld_acc = '0;
  logic        ld_ext = 1'b0;
  logic [15:0] acc_q;
  logic        ext_q, skip_req, halt_req, sc_clr;

  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] m_acc = '0;
  logic        m_ext = 1'b0;

  always #10 clk = ~clk;

  acc_regop_unit dut_i (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_sel(op_sel),
    .ld_en(ld_en), .ld_acc(ld_acc), .ld_ext(ld_ext),
    .acc_q(acc_q), .ext_q(ext_q), .skip_req(skip_req),
    .halt_req(halt_req), .sc_clr(sc_clr)
  );

  // {ext, acc} next state after an execute step
  function automatic logic [16:0] exp_next(input logic [15:0] a, input logic e,
                                           input logic [11:0] s);
    logic [16:0] pr, pl;
    logic [15:0] an;
    logic        en;
    pr = {a[0], e, a[15:1]};
    pl = {a[15], a[14:0], e};
    an = s[11] ? 16'h0000 : s[9] ? (a ^ 16'hFFFF) : s[7] ? pr[15:0] :
         s[6] ? pl[15:0] : s[5] ? 16'((32'(a) + 1) % 65536) : a;
    en = s[10] ? 1'b0 : s[8] ? !e : s[7] ? pr[16] : s[6] ? pl[16] : e;
    return {en, an};
  endfunction

  function automatic logic exp_skip(input logic [15:0] a, input logic e,
                                    input logic [11:0] s);
    return (s[4] && a < 16'h8000) || (s[3] && a >= 16'h8000) ||
           (s[2] && a == 0) || (s[1] && e == 0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic [11:0] s, input logic ld,
                      input logic [15:0] la, input logic le);
    logic [16:0] nx;
    exec_en = en; op_sel = s; ld_en = ld; ld_acc = la; ld_ext = le;
    #5;
    if (en) begin
      chk("R3 sc_clr", 32'(sc_clr), 32'd1);
      chk("R9/R10/R12 skip", 32'(skip_req), 32'(exp_skip(m_acc, m_ext, s)));
      chk("R11 halt", 32'(halt_req), 32'(s[0]));
      nx = exp_next(m_acc, m_ext, s);
      m_acc = nx[15:0]; m_ext = nx[16];
    end else begin
      chk("R2 idle outputs", {29'd0, skip_req, halt_req, sc_clr}, 32'd0);
      if (ld) begin m_acc = la; m_ext = le; end
    end
    @(negedge clk);
    chk(en ? "R4-R8/R12/R13 acc" : "R2 acc", 32'(acc_q), 32'(m_acc));
    chk(en ? "R4-R8/R12/R13 ext" : "R2 ext", 32'(ext_q), 32'(m_ext));
  endtask

  task automatic load(input logic [15:0] a, input logic e);
    step(1'b0, 12'h000, 1'b1, a, e);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R1 reset acc", 32'(acc_q), 32'd0);
    chk("R1 reset ext", 32'(ext_q), 32'd0);
    rst_n = 1'b1;
    // directed corner cases
    load(16'hFFFF, 1'b1); step(1, 12'h020, 0, 0, 0);               // R8 wrap, ext kept
    chk("R8 wrap", 32'(acc_q), 32'h0000);
    step(1, 12'h004, 0, 0, 0);                                     // R10 zero skip
    load(16'h8001, 1'b1); step(1, 12'h080, 0, 0, 0);               // R6
    chk("R6 rotate right", {15'd0, ext_q, acc_q}, 32'h1C000);
    load(16'h8001, 1'b0); step(1, 12'h040, 0, 0, 0);               // R7
    chk("R7 rotate left", {15'd0, ext_q, acc_q}, 32'h10002);
    load(16'h8000, 1'b0); step(1, 12'h010, 0, 0, 0); step(1, 12'h008, 0, 0, 0); // R9
    step(1, 12'h002, 0, 0, 0);                                     // R10 flag zero
    load(16'h1234, 1'b1); step(1, 12'hA00, 0, 0, 0);               // R12 clear beats invert
    chk("R12 clear wins", 32'(acc_q), 32'h0000);
    step(1, 12'h300, 0, 0, 0); step(1, 12'h400, 0, 0, 0);          // R5, R4
    step(1, 12'h001, 0, 0, 0);                                     // R11
    step(1, 12'h000, 0, 0, 0);                                     // R3 empty select
    step(1, 12'h800, 1, 16'hBEEF, 1'b1);                           // R13
    chk("R13 exec wins", 32'(acc_q), 32'h0000);
    step(0, 12'hFFF, 0, 0, 0);                                     // R2 select ignored
    load(16'h7FFF, 1'b0); step(1, 12'h0A0, 0, 0, 0);               // R12 rotate beats inc
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] s;
      int k;
      k = int'($urandom % 4);
      s = (k == 1) ? 12'($urandom) : (k == 2) ? 12'h000 : 12'h001 << ($urandom % 12);
      step(($urandom % 5) != 0, s, ($urandom % 3) == 0, 16'($urandom), 1'($urandom));
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule